// File: doc/BRIEF.md
# SIMD Lane Move and Duplicate Unit

This unit moves data between a 32-bit scalar register value and vector registers. It performs three operations. Insert overwrites one lane of a 64-bit vector with the low bits of the scalar. Extract pulls one lane of a 64-bit vector out into a 32-bit result, with zero or sign extension. Duplicate copies the low byte, halfword or word of the scalar into every lane of a 128-bit vector.

The lane width and the lane number both come from a 4-bit selector made of two raw instruction fields. `sel_hi` carries instruction bits 22:21 and forms selector bits 3:2. `sel_lo` carries instruction bits 6:5 and forms selector bits 1:0. Extension on extract is chosen by `u_bit`, which is instruction bit 23.

Results are computed combinationally and captured in an output register. A two-state output controller sets the valid strobe:
- State ST_EMPTY moves to ST_FULL when a valid input arrives.
- State ST_FULL stays in ST_FULL on another valid input and falls back to ST_EMPTY when there is none.

Top module: `lane_xfer_unit`

## Requirements
- R1: After reset is released, and before any valid input, `out_valid`, `illegal`, `ins_vec`, `ext_word` and `dup_vec` are all zero.
- R2: When (selector AND 4'b1011) is zero, the lane is a 32-bit word. Selector bit 2 (instruction bit 21) picks the word: 0 for bits 31:0, 1 for bits 63:32.
- R3: When selector bit 3 is 1, the lane is a byte. The lane number is selector bits 2:0, and byte n occupies bits 8n+7:8n.
- R4: When R2 and R3 do not apply and selector bit 0 is 1, the lane is a halfword. The lane number is selector bits 2:1, and halfword n occupies bits 16n+15:16n.
- R5: Insert (`op`=2'b00) writes the low lane-width bits of `scalar` into the addressed lane of `vec_in` and presents the result on `ins_vec`. Every other bit of `vec_in` passes through unchanged.
- R6: Extract (`op`=2'b01) returns the addressed lane on `ext_word`. For byte and halfword lanes the value is zero-extended when `u_bit` is 1 and sign-extended when `u_bit` is 0. A word lane is returned as is.
- R7: Duplicate (`op`=2'b10) picks the lane size as follows: 16 bits when `sel_lo[0]` is 1, else 8 bits when `sel_hi[1]` is 1, else 32 bits. It fills all of `dup_vec` with the low part of `scalar` at that size. Duplicate is never illegal.
- R8: The input is illegal when `op`=2'b11, or when insert or extract uses selector 4'b0010 or 4'b0110. An illegal input raises `illegal`, returns `vec_in` unchanged on `ins_vec`, and sets `ext_word` and `dup_vec` to zero.
- R9: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. All result outputs hold their values while no valid input arrives.
- R10: For a legal operation, the outputs that do not belong to that operation are fixed. `ins_vec` equals `vec_in`, `ext_word` is zero, and `dup_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 2 | Operation: 00 insert, 01 extract, 10 duplicate, 11 reserved |
| sel_hi | input | 2 | Instruction bits 22:21 (selector bits 3:2) |
| sel_lo | input | 2 | Instruction bits 6:5 (selector bits 1:0) |
| u_bit | input | 1 | Instruction bit 23: 1 zero-extends, 0 sign-extends |
| scalar | input | 32 | Scalar register value |
| vec_in | input | 64 | Old 64-bit vector contents |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| illegal | output | 1 | Registered illegal-encoding flag |
| ins_vec | output | 64 | Insert result, or `vec_in` unchanged |
| ext_word | output | 32 | Extract result |
| dup_vec | output | 128 | Duplicate result |

## Verification
The bench sweeps all 16 selector values against every operation code and both `u_bit` values. It uses scalars and vectors whose lane values carry set and clear top bits, so each extension choice is exercised.

The sweep targets specific faults:
- **Decode order.** Selectors 4'b1001 and 4'b1101 must decode as bytes, not halfwords. A design that tests bit 0 before bit 3 writes two bytes in the wrong place.
- **Extension.** A unit that ignores `u_bit` or extends from the wrong bit gives a wrong upper half on extract of 0x80 or 0x8001.
- **Insert masking.** A mask off by one lane clobbers a neighbouring byte.
- **Illegal selectors.** Treating 4'b0010 or 4'b0110 as a word access writes `vec_in` where it should stay unchanged.
- **Duplicate priority.** Letting bit 22 win over bit 5 replicates bytes instead of halfwords.

// File: rtl/lane_xfer_pkg.sv
package lane_xfer_pkg;

    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_EXTRACT = 2'd1,
        OP_DUP     = 2'd2,
        OP_RSVD    = 2'd3
    } lane_op_e;

    typedef enum logic [1:0] {
        LK_WORD = 2'd0,
        LK_HALF = 2'd1,
        LK_BYTE = 2'd2,
        LK_NONE = 2'd3
    } lane_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_xfer_pkg::*;
(
    input  logic [3:0]  sel,
    output lane_kind_e  kind,
    output logic [2:0]  idx
);

    // Priority: word pattern, then byte (bit 3), then halfword (bit 0).
    always_comb begin
        kind = LK_NONE;
        idx  = 3'd0;
        if ((sel & 4'b1011) == 4'b0000) begin
            kind = LK_WORD;
            idx  = {2'b00, sel[2]};
        end else if (sel[3]) begin
            kind = LK_BYTE;
            idx  = sel[2:0];
        end else if (sel[0]) begin
            kind = LK_HALF;
            idx  = {1'b0, sel[2:1]};
        end
    end

endmodule

// File: rtl/lane_insert.sv
module lane_insert
    import lane_xfer_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [2*WORD_W-1:0] vec_in,
    input  logic [WORD_W-1:0]   scalar,
    input  lane_kind_e          kind,
    input  logic [2:0]          idx,
    output logic [2*WORD_W-1:0] vec_out
);

    localparam int VEC_W  = 2 * WORD_W;
    localparam int BYTE_W = WORD_W / 4;
    localparam int NSLOT  = VEC_W / BYTE_W;

    // Each byte slot decides on its own whether it is overwritten and by
    // which byte of the scalar.
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        logic [BYTE_W-1:0] slot;
        always_comb begin
            slot = vec_in[j*BYTE_W +: BYTE_W];
            if (kind == LK_BYTE && idx == 3'(j)) begin
                slot = scalar[BYTE_W-1:0];
            end else if (kind == LK_HALF && idx[1:0] == 2'(j / 2)) begin
                slot = scalar[(j % 2)*BYTE_W +: BYTE_W];
            end else if (kind == LK_WORD && idx[0] == 1'(j / 4)) begin
                slot = scalar[(j % 4)*BYTE_W +: BYTE_W];
            end
        end
        assign vec_out[j*BYTE_W +: BYTE_W] = slot;
    end

endmodule

// File: rtl/lane_extract.sv
module lane_extract
    import lane_xfer_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [2*WORD_W-1:0] vec_in,
    input  lane_kind_e          kind,
    input  logic [2:0]          idx,
    input  logic                u_bit,
    output logic [WORD_W-1:0]   word_out
);

    localparam int BYTE_W = WORD_W / 4;
    localparam int HALF_W = WORD_W / 2;

    logic [BYTE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;
    logic [WORD_W-1:0] word_v;
    logic              byte_fill;
    logic              half_fill;

    assign byte_v = BYTE_W'(vec_in >> (idx * BYTE_W));
    assign half_v = HALF_W'(vec_in >> (idx[1:0] * HALF_W));
    assign word_v = WORD_W'(vec_in >> (idx[0] * WORD_W));

    // Upper fill bit: zero when unsigned, lane sign bit when signed.
    assign byte_fill = ~u_bit & byte_v[BYTE_W-1];
    assign half_fill = ~u_bit & half_v[HALF_W-1];

    always_comb begin
        unique case (kind)
            LK_BYTE: word_out = {{(WORD_W-BYTE_W){byte_fill}}, byte_v};
            LK_HALF: word_out = {{(WORD_W-HALF_W){half_fill}}, half_v};
            LK_WORD: word_out = word_v;
            default: word_out = '0;
        endcase
    end

endmodule

// File: rtl/lane_dup.sv
module lane_dup #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]   scalar,
    input  logic                size_half,
    input  logic                size_byte,
    output logic [4*WORD_W-1:0] dup_vec
);

    localparam int BYTE_W = WORD_W / 4;
    localparam int HALF_W = WORD_W / 2;
    localparam int NWORD  = 4;

    logic [WORD_W-1:0] pattern;

    // Halfword size wins over byte size.
    always_comb begin
        if (size_half) begin
            pattern = {(WORD_W/HALF_W){scalar[HALF_W-1:0]}};
        end else if (size_byte) begin
            pattern = {(WORD_W/BYTE_W){scalar[BYTE_W-1:0]}};
        end else begin
            pattern = scalar;
        end
    end

    for (genvar k = 0; k < NWORD; k++) begin : g_word
        assign dup_vec[k*WORD_W +: WORD_W] = pattern;
    end

endmodule

// File: rtl/lane_xfer_unit.sv
module lane_xfer_unit
    import lane_xfer_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            op,
    input  logic [1:0]            sel_hi,
    input  logic [1:0]            sel_lo,
    input  logic                  u_bit,
    input  logic [WORD_W-1:0]     scalar,
    input  logic [2*WORD_W-1:0]   vec_in,
    output logic                  out_valid,
    output logic                  illegal,
    output logic [2*WORD_W-1:0]   ins_vec,
    output logic [WORD_W-1:0]     ext_word,
    output logic [4*WORD_W-1:0]   dup_vec
);

    localparam int VEC_W  = 2 * WORD_W;
    localparam int DUP_W  = 4 * WORD_W;
    localparam int BYTE_W = WORD_W / 4;
    localparam logic [VEC_W-1:0] BYTE_MASK = VEC_W'({BYTE_W{1'b1}});

    lane_op_e    op_e;
    lane_kind_e  kind;
    logic [2:0]  idx;
    logic [VEC_W-1:0]  ins_res;
    logic [WORD_W-1:0] ext_res;
    logic [DUP_W-1:0]  dup_res;
    logic              illegal_c;
    logic [VEC_W-1:0]  ins_c;
    logic [WORD_W-1:0] ext_c;
    logic [DUP_W-1:0]  dup_c;
    out_state_e        state_q;
    out_state_e        state_d;

    assign op_e = lane_op_e'(op);

    lane_decode u_decode (
        .sel  ({sel_hi, sel_lo}),
        .kind (kind),
        .idx  (idx)
    );

    lane_insert #(.WORD_W(WORD_W)) u_insert (
        .vec_in  (vec_in),
        .scalar  (scalar),
        .kind    (kind),
        .idx     (idx),
        .vec_out (ins_res)
    );

    lane_extract #(.WORD_W(WORD_W)) u_extract (
        .vec_in   (vec_in),
        .kind     (kind),
        .idx      (idx),
        .u_bit    (u_bit),
        .word_out (ext_res)
    );

    lane_dup #(.WORD_W(WORD_W)) u_dup (
        .scalar    (scalar),
        .size_half (sel_lo[0]),
        .size_byte (sel_hi[1]),
        .dup_vec   (dup_res)
    );

    // Result selection per operation.
    always_comb begin
        illegal_c = (op_e == OP_RSVD) ||
                    ((op_e == OP_INSERT || op_e == OP_EXTRACT) && kind == LK_NONE);
        ins_c = (op_e == OP_INSERT && !illegal_c) ? ins_res : vec_in;
        ext_c = (op_e == OP_EXTRACT && !illegal_c) ? ext_res : '0;
        dup_c = (op_e == OP_DUP) ? dup_res : '0;
    end

    // Output controller: next-state logic.
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers: load on a valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal  <= 1'b0;
            ins_vec  <= '0;
            ext_word <= '0;
            dup_vec  <= '0;
        end else if (in_valid) begin
            illegal  <= illegal_c;
            ins_vec  <= ins_c;
            ext_word <= ext_c;
            dup_vec  <= dup_c;
        end
    end

    assign out_valid = (state_q == ST_FULL);

    // R9: strobe follows the request by one cycle
    a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: a byte insert leaves every other byte untouched
    a_r5_insert_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_INSERT && kind == LK_BYTE) |=>
        (((ins_vec ^ $past(vec_in)) & ~(BYTE_MASK << ($past(idx) * BYTE_W))) == '0));

    // R6: unsigned byte extract has a zero upper part
    a_r6_unsigned_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_EXTRACT && kind == LK_BYTE && u_bit) |=>
        (ext_word[WORD_W-1:BYTE_W] == '0));

    // R7: both 64-bit halves of a duplicate are equal
    a_r7_dup_halves_match: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_DUP) |=> (dup_vec[DUP_W-1:VEC_W] == dup_vec[VEC_W-1:0]));

    // R8: an illegal encoding passes the vector through unchanged
    a_r8_illegal_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_RSVD) |=> (illegal && ins_vec == $past(vec_in)));

endmodule

// File: tb/test_lane_xfer_unit.sv
module test_lane_xfer_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [1:0]   sel_hi = 2'd0;
    logic [1:0]   sel_lo = 2'd0;
    logic         u_bit = 1'b0;
    logic [31:0]  scalar = '0;
    logic [63:0]  vec_in = '0;
    logic         out_valid;
    logic         illegal;
    logic [63:0]  ins_vec;
    logic [31:0]  ext_word;
    logic [127:0] dup_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lane_xfer_unit i_lane_xfer_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .sel_hi    (sel_hi),
        .sel_lo    (sel_lo),
        .u_bit     (u_bit),
        .scalar    (scalar),
        .vec_in    (vec_in),
        .out_valid (out_valid),
        .illegal   (illegal),
        .ins_vec   (ins_vec),
        .ext_word  (ext_word),
        .dup_vec   (dup_vec)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [3:0] s, input logic u,
                          input logic [31:0] sc, input logic [63:0] v);
        int kind;
        int ix;
        logic ill;
        logic [63:0]  e_ins;
        logic [31:0]  e_ext;
        logic [127:0] e_dup;
        logic [15:0]  h;
        logic [7:0]   b;
        string tag;

        @(negedge clk);
        in_valid = 1'b1; op = o; sel_hi = s[3:2]; sel_lo = s[1:0];
        u_bit = u; scalar = sc; vec_in = v;
        @(negedge clk);
        in_valid = 1'b0;

        // Lane decode: 0 word, 1 half, 2 byte, 3 none.
        if ((s & 4'b1011) == 4'b0000) begin kind = 0; ix = int'(s[2]); tag = "R2"; end
        else if (s[3])                begin kind = 2; ix = int'(s[2:0]); tag = "R3"; end
        else if (s[0])                begin kind = 1; ix = int'(s[2:1]); tag = "R4"; end
        else                          begin kind = 3; ix = 0; tag = "R8"; end

        ill = (o == 2'd3) || (o != 2'd2 && kind == 3);
        e_ins = v;
        e_ext = '0;
        e_dup = '0;
        if (o == 2'd0 && !ill) begin
            if (kind == 0) e_ins[ix*32 +: 32] = sc;
            else if (kind == 1) e_ins[ix*16 +: 16] = sc[15:0];
            else e_ins[ix*8 +: 8] = sc[7:0];
        end
        if (o == 2'd1 && !ill) begin
            if (kind == 0) e_ext = v[ix*32 +: 32];
            else if (kind == 1) begin
                h = v[ix*16 +: 16];
                e_ext = u ? {16'h0, h} : {{16{h[15]}}, h};
            end else begin
                b = v[ix*8 +: 8];
                e_ext = u ? {24'h0, b} : {{24{b[7]}}, b};
            end
        end
        if (o == 2'd2) begin
            if (s[0])      e_dup = {8{sc[15:0]}};
            else if (s[3]) e_dup = {16{sc[7:0]}};
            else           e_dup = {4{sc}};
        end

        check("R9", "out_valid", 128'(out_valid), 128'(1'b1));
        check("R8", "illegal", 128'(illegal), 128'(ill));
        if (o == 2'd0) begin
            check(ill ? "R8" : tag, "insert lane", 128'(ins_vec), 128'(e_ins));
            check("R5", "insert vector", 128'(ins_vec), 128'(e_ins));
        end else begin
            check(ill ? "R8" : "R10", "ins_vec passthru", 128'(ins_vec), 128'(e_ins));
        end
        if (o == 2'd1) begin
            check("R6", "extract word", 128'(ext_word), 128'(e_ext));
            check(ill ? "R8" : tag, "extract lane", 128'(ext_word), 128'(e_ext));
        end else begin
            check(ill ? "R8" : "R10", "ext_word zero", 128'(ext_word), 128'(e_ext));
        end
        if (o == 2'd2) check("R7", "duplicate", dup_vec, e_dup);
        else check(ill ? "R8" : "R10", "dup_vec zero", dup_vec, e_dup);
    endtask

    initial begin
        logic [31:0] scs [3];
        logic [63:0] vs  [3];
        logic [63:0] held;
        scs[0] = 32'h8001_F0A5; scs[1] = 32'h1234_5678; scs[2] = 32'h7F7F_FF80;
        vs[0]  = 64'hFEDC_BA98_7654_3210;
        vs[1]  = 64'h8081_8283_8485_8687;
        vs[2]  = 64'h7F00_8000_0080_FF7F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", 128'(out_valid), 128'(0));
        check("R1", "illegal", 128'(illegal), 128'(0));
        check("R1", "ins_vec", 128'(ins_vec), 128'(0));
        check("R1", "ext_word", 128'(ext_word), 128'(0));
        check("R1", "dup_vec", dup_vec, 128'(0));

        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 4; o++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int u = 0; u < 2; u++) begin
                        run_op(2'(o), 4'(s), 1'(u), scs[p], vs[(p + s) % 3]);
                    end
                end
            end
        end

        // R9: outputs hold and strobe drops with no valid input
        run_op(2'd0, 4'b1111, 1'b0, 32'hAB, 64'h0);
        held = ins_vec;
        vec_in = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R9", "strobe low when idle", 128'(out_valid), 128'(0));
        check("R9", "ins_vec held", 128'(ins_vec), 128'(held));
        check("R9", "ins_vec value", 128'(ins_vec), 128'(64'hAB00_0000_0000_0000));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule